// File: doc/BRIEF.md
# Card Offset Solenoid Sequencer

This block decides, card by card, whether the offset solenoid of a card punch fires. The host controller can ask for an offset at any moment in the punch cycle, and a maintenance check switch can force offsets without the host. Either request is synchronised into the clock domain and held in a pending latch. When the timing chain reaches its energise step, the pending request moves into an active flag for the current card. The solenoid is driven while that flag is set and the timing chain is between its energise and release steps. The deflection therefore ends well before the card reaches the stacker.

The timing chain is presented as a strobe with a step index. A separate fifth-pulse clear input releases the active flag at the end of the offset phase. Master clear empties every latch and forces the drive low in the same cycle. A request that reaches the pending latch on or after the energise step is kept for the following card.

Top module: `offs_sol_seq`

## Requirements
- R1: A host request pulse of at least one clock cycle sets the pending latch after SYNC_STAGES+1 rising edges. The next strobe with index ON_STEP then raises `sol_drive` on the edge that samples that strobe.
- R2: While `chk_en` is held at 1, every strobe with index ON_STEP raises `sol_drive` for that card, with no host request.
- R3: A strobe with index OFF_STEP drops `sol_drive` on the edge that samples it.
- R4: `sol_drive` is 0 outside the window that opens at the ON_STEP strobe and closes at the OFF_STEP strobe, even when a request is pending.
- R5: `pulse5_clr` clears the active flag on the next edge. This drops `sol_drive` even inside the window, and a later ON_STEP strobe without a new request does not fire. `pulse5_clr` has priority over a coincident ON_STEP strobe.
- R6: A request that reaches the pending latch on the same edge as the ON_STEP strobe, or after it, does not fire the current card. It fires at the next ON_STEP strobe.
- R7: While `mclr` is 1, `sol_drive` is 0 in that same cycle. On the next edge the pending latch, the active flag and the window are all cleared.
- R8: A step strobe changes nothing when its index is neither ON_STEP nor OFF_STEP, or when the index is NUM_STEPS or above. The value of `step_idx` changes nothing while `step_stb` is 0.
- R9: After reset `sol_drive` is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclr | input | 1 | Master clear, synchronous, also gates the drive at once |
| host_req | input | 1 | Offset request from the host, asynchronous |
| chk_en | input | 1 | Maintenance check switch, asynchronous level |
| step_stb | input | 1 | One-cycle strobe marking a timing-chain step |
| step_idx | input | $clog2(NUM_STEPS) | Index of the step being strobed |
| pulse5_clr | input | 1 | Fifth timing pulse, releases the active offset |
| sol_drive | output | 1 | Offset solenoid drive |

## Verification
The bench builds the block with NUM_STEPS=7, ON_STEP=4, OFF_STEP=5 and SYNC_STAGES=2. This configuration leaves the encoding 7 of the 3-bit index unused, so the out-of-range strobe filter can be driven directly. With only seven steps, every index can be swept in order, both with a request pending and without one. A two-stage synchroniser lets the bench place the arrival of a request exactly on the energise edge, which exercises the next-card rule at its boundary.

// File: rtl/offs_pkg.sv
package offs_pkg;

  typedef struct packed {
    logic on_hit;
    logic off_hit;
  } step_ev_t;

  // True when a valid strobe names the given step.
  function automatic logic step_match(input logic stb, input logic [31:0] idx,
                                      input int unsigned target,
                                      input int unsigned nsteps);
    return stb && (idx < nsteps) && (idx == target);
  endfunction

  // Next window state from the decoded step events.
  function automatic logic win_next(input logic win, input step_ev_t ev);
    if (ev.on_hit)       return 1'b1;
    else if (ev.off_hit) return 1'b0;
    else                 return win;
  endfunction

  // Next pending-latch value: consumed at the energise step, while a request
  // seen on that same edge is kept for the following card.
  function automatic logic pend_next(input logic pend, input logic req,
                                     input logic on_hit);
    if (on_hit) return req;
    else        return pend | req;
  endfunction

endpackage

// File: rtl/offs_sync.sv
module offs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else if (STAGES == 1) sr <= d;
        else sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/offs_step_decode.sv
module offs_step_decode
  import offs_pkg::*;
#(
  parameter int NUM_STEPS = 8,
  parameter int ON_STEP   = 4,
  parameter int OFF_STEP  = 5,
  parameter int STEP_W    = 3
) (
  input  logic              step_stb,
  input  logic [STEP_W-1:0] step_idx,
  output step_ev_t          ev
);
  logic [31:0] idx_ext;
  assign idx_ext    = {{(32-STEP_W){1'b0}}, step_idx};
  assign ev.on_hit  = step_match(step_stb, idx_ext, ON_STEP, NUM_STEPS);
  assign ev.off_hit = step_match(step_stb, idx_ext, OFF_STEP, NUM_STEPS);
endmodule

// File: rtl/offs_window.sv
module offs_window
  import offs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mclr,
  input  step_ev_t ev,
  output logic     win
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    win <= 1'b0;
    else if (mclr) win <= 1'b0;
    else           win <= win_next(win, ev);
  end
endmodule

// File: rtl/offs_req_latch.sv
module offs_req_latch
  import offs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mclr,
  input  logic     req_in,
  input  logic     clr5,
  input  step_ev_t ev,
  output logic     pend,
  output logic     active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      active <= 1'b0;
    end else if (mclr) begin
      pend   <= 1'b0;
      active <= 1'b0;
    end else begin
      pend <= pend_next(pend, req_in, ev.on_hit);
      if (clr5)                   active <= 1'b0;
      else if (ev.on_hit && pend) active <= 1'b1;
    end
  end
endmodule

// File: rtl/offs_sol_seq.sv
module offs_sol_seq
  import offs_pkg::*;
#(
  parameter int NUM_STEPS   = 8,
  parameter int ON_STEP     = 4,
  parameter int OFF_STEP    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mclr,
  input  logic                         host_req,
  input  logic                         chk_en,
  input  logic                         step_stb,
  input  logic [$clog2(NUM_STEPS)-1:0] step_idx,
  input  logic                         pulse5_clr,
  output logic                         sol_drive
);
  localparam int STEP_W = $clog2(NUM_STEPS);

  logic     host_sync;
  logic     chk_sync;
  logic     req_sync;
  step_ev_t step_ev;
  logic     pend_q;
  logic     active_q;
  logic     win_q;

  offs_sync #(.STAGES(SYNC_STAGES)) host_sync_i (
    .clk(clk), .rst_n(rst_n), .d(host_req), .q(host_sync));

  offs_sync #(.STAGES(SYNC_STAGES)) chk_sync_i (
    .clk(clk), .rst_n(rst_n), .d(chk_en), .q(chk_sync));

  assign req_sync = host_sync | chk_sync;

  offs_step_decode #(
    .NUM_STEPS(NUM_STEPS), .ON_STEP(ON_STEP),
    .OFF_STEP(OFF_STEP), .STEP_W(STEP_W)
  ) dec_i (
    .step_stb(step_stb), .step_idx(step_idx), .ev(step_ev));

  offs_req_latch latch_i (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .req_in(req_sync),
    .clr5(pulse5_clr), .ev(step_ev), .pend(pend_q), .active(active_q));

  offs_window win_i (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .ev(step_ev), .win(win_q));

  assign sol_drive = active_q & win_q & ~mclr;
endmodule

// File: rtl/offs_seq_chk.sv
module offs_seq_chk #(
  parameter int NUM_STEPS = 8,
  parameter int ON_STEP   = 4,
  parameter int OFF_STEP  = 5,
  parameter int STEP_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mclr,
  input logic              step_stb,
  input logic [STEP_W-1:0] step_idx,
  input logic              pulse5_clr,
  input logic              sol_drive,
  input logic              req_sync,
  input logic              pend_q,
  input logic              active_q
);
  logic on_port, off_port, port_win;
  assign on_port  = step_stb && (int'(step_idx) == ON_STEP)  && (int'(step_idx) < NUM_STEPS);
  assign off_port = step_stb && (int'(step_idx) == OFF_STEP) && (int'(step_idx) < NUM_STEPS);

  // Window rebuilt from the step ports alone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        port_win <= 1'b0;
    else if (mclr)     port_win <= 1'b0;
    else if (on_port)  port_win <= 1'b1;
    else if (off_port) port_win <= 1'b0;
  end

  // R4
  outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sol_drive |-> port_win);

  // R1
  rise_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sol_drive) |-> $past(on_port));

  // R3
  off_step_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_port && !on_port) |=> !sol_drive);

  // R5
  fifth_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse5_clr |=> (!active_q && !sol_drive));

  // R6
  next_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_port && req_sync && !mclr) |=> pend_q);

  // R7
  mclr_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |-> !sol_drive);

  // R7
  mclr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (!pend_q && !active_q && !port_win));
endmodule

bind offs_sol_seq offs_seq_chk #(
  .NUM_STEPS(NUM_STEPS), .ON_STEP(ON_STEP),
  .OFF_STEP(OFF_STEP), .STEP_W($clog2(NUM_STEPS))
) chk_i (
  .clk(clk), .rst_n(rst_n), .mclr(mclr), .step_stb(step_stb),
  .step_idx(step_idx), .pulse5_clr(pulse5_clr), .sol_drive(sol_drive),
  .req_sync(req_sync), .pend_q(pend_q), .active_q(active_q));

// File: tb/offs_sol_seq_tb.sv
module offs_sol_seq_tb_top;
  localparam int NSTEPS = 7;
  localparam int ON     = 4;
  localparam int OFF    = 5;
  localparam int SYNC   = 2;
  localparam int SW     = $clog2(NSTEPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclr = 1'b0, host_req = 1'b0, chk_en = 1'b0;
  logic step_stb = 1'b0, pulse5_clr = 1'b0;
  logic [SW-1:0] step_idx = '0;
  logic sol_drive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  offs_sol_seq #(.NUM_STEPS(NSTEPS), .ON_STEP(ON), .OFF_STEP(OFF),
                 .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .host_req(host_req),
    .chk_en(chk_en), .step_stb(step_stb), .step_idx(step_idx),
    .pulse5_clr(pulse5_clr), .sol_drive(sol_drive));

  task automatic check(input logic exp, input string tag);
    checks++;
    if (sol_drive !== exp) begin
      failures++;
      $display("FAIL %s sol_drive actual=%0b expected=%0b", tag, sol_drive, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input int idx);
    step_stb = 1'b1;
    step_idx = SW'(idx);
    tick();
    step_stb = 1'b0;
  endtask

  task automatic clear5();
    pulse5_clr = 1'b1;
    tick();
    pulse5_clr = 1'b0;
  endtask

  task automatic request();
    host_req = 1'b1;
    tick();
    host_req = 1'b0;
    tick(SYNC + 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    check(1'b0, "R9 reset");

    // R1 R3 R8: request pending, every step in order
    request();
    for (int s = 0; s < NSTEPS; s++) begin
      strobe(s);
      check((s >= ON && s < OFF) ? 1'b1 : 1'b0, $sformatf("R1/R3/R8 sweep step %0d", s));
    end
    clear5();
    check(1'b0, "R5 after sweep");

    // R4: nothing pending, every step in order
    for (int s = 0; s < NSTEPS; s++) begin
      strobe(s);
      check(1'b0, $sformatf("R4 idle step %0d", s));
    end

    // R4: latch set but no ON step yet
    request();
    strobe(OFF);
    tick(3);
    check(1'b0, "R4 pending outside window");
    strobe(ON);
    check(1'b1, "R1 pending later fires");

    // R8: out-of-range index and idx without strobe do not close window
    strobe(NSTEPS);
    check(1'b1, "R8 out-of-range index");
    step_idx = SW'(OFF);
    tick(2);
    check(1'b1, "R8 idx without strobe");
    strobe(OFF);
    check(1'b0, "R3 off drop");
    clear5();

    // R5: fifth clear inside the window
    request();
    strobe(ON);
    check(1'b1, "R5 setup");
    clear5();
    check(1'b0, "R5 drop in window");
    strobe(OFF);
    strobe(ON);
    check(1'b0, "R5 latch released");
    strobe(OFF);

    // R6: request lands on the ON edge
    host_req = 1'b1;
    tick();
    host_req = 1'b0;
    tick();
    strobe(ON);
    check(1'b0, "R6 coincident request");
    strobe(OFF);
    clear5();
    strobe(ON);
    check(1'b1, "R6 next card fires");
    strobe(OFF);
    clear5();

    // R6: request after ON step
    strobe(ON);
    request();
    check(1'b0, "R6 late request");
    strobe(OFF);
    clear5();
    strobe(ON);
    check(1'b1, "R6 late request next card");
    strobe(OFF);
    clear5();

    // R2: maintenance check switch held on
    chk_en = 1'b1;
    tick(SYNC + 2);
    for (int c = 0; c < 3; c++) begin
      strobe(ON);
      check(1'b1, $sformatf("R2 card %0d on", c));
      strobe(OFF);
      check(1'b0, $sformatf("R2 card %0d off", c));
      clear5();
    end
    chk_en = 1'b0;
    tick(SYNC + 2);

    // R7: master clear empties pending latch left by check switch
    mclr = 1'b1;
    tick();
    mclr = 1'b0;
    strobe(ON);
    check(1'b0, "R7 pending cleared");
    strobe(OFF);

    // R7: immediate drop and cleared active flag
    request();
    strobe(ON);
    check(1'b1, "R7 setup");
    mclr = 1'b1;
    #1;
    check(1'b0, "R7 same-cycle drop");
    tick();
    mclr = 1'b0;
    tick();
    check(1'b0, "R7 stays low");
    strobe(ON);
    check(1'b0, "R7 active cleared");
    strobe(OFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule